// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an on-chip user port and an external asynchronous static RAM with a 20-bit address, a 4-bit data bus and three active-low strobes: chip enable, output enable and write enable. The user raises a request with a write flag, an address and write data. The controller turns each request into a strobe sequence whose every phase is long enough for the RAM. When the access completes, it raises a one-cycle done pulse. For a read, the fetched word is on the read-data output during that pulse.

Each timing limit of the RAM is a parameter in picoseconds. The controller converts it to a whole number of clock cycles at elaboration, from a clock-period parameter. Writes end on the rise of write enable and keep output enable high for the whole cycle, so the RAM never drives the bus while the controller does. After a read, the RAM needs time to release the bus, so both enables stay high for that time before a new access may begin.

The shared bus is split into three signals: an output word, an input word and an output-enable for the driver.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip enable, output enable and write enable are high (1), the data driver is off (`ram_dout_en` = 0) and `done` is 0.
- R2: A write spends 1 setup cycle with chip enable low and write enable high. Write enable is then low for PW cycles, with PW the largest of the cycle counts for write-pulse width, address setup to write end and data setup. A hold phase of at least 1 cycle follows with write enable high. Setup, pulse and hold together last at least the write-cycle count.
- R3: Output enable stays high for the whole of a write. `ram_dout_en` is 1 exactly in the cycles where write enable is low and in the hold phase after it.
- R4: A read holds chip enable and output enable low and write enable high for RD cycles, with the driver off. RD is the largest of the cycle counts for address access, output-enable access and read cycle.
- R5: Read data is sampled from `ram_din` in the last cycle of the read window. It appears on `rd_data` in the cycle where `done` is high.
- R6: After a read, chip enable and output enable are both high for TURN cycles, the cycle count of the bus-release time, before another request can be taken.
- R7: `done` is a one-cycle pulse. After a write, it comes in the cycle that follows the hold phase. After a read, it comes in the first turnaround cycle.
- R8: A request is taken only when the controller is idle. A request raised while an access is in progress is ignored. `ram_addr` and `ram_dout` keep the values captured when the request was taken until the access ends.
- R9: The data driver is never on while output enable is low.
- R10: Each cycle count is the ceiling of the time divided by the clock period, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, taken when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Data to write |
| rd_data | output | 4 | Word fetched by the last read |
| done | output | 1 | One-cycle completion pulse |
| ram_addr | output | 20 | RAM address lines |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dout | output | 4 | Data driven towards the RAM |
| ram_din | input | 4 | Data returned from the RAM |
| ram_dout_en | output | 1 | Enable for the data-bus driver |

## Verification
The bench uses a clock period that makes the read window 4 cycles, the write pulse 3 cycles and the turnaround 2 cycles. A phase that is one cycle short therefore shows up as a wrong strobe in a specific cycle, or as a stale word read back from the bench RAM model.

Requests are held high across busy cycles, with changing address and data. A controller that re-latched them would put the wrong address on the RAM, and a later read of the wrongly targeted location would return nonzero data.

Reads directly followed by writes exercise the turnaround. A missing release gap would show the data driver switching on while output enable is still low, or the new access starting early.

Accesses at address 0 and at the top address, repeated writes to one location, and reads of locations never written cover the edges of the address range and the stale-data cases.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_TURN,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dout_en;
    } strobes_t;

    localparam strobes_t STROBES_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dout_en: 1'b0};

    // ceiling division of a time by the clock period, never below one cycle
    function automatic int cycles_for(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // strobe levels for each phase of an access
    function automatic strobes_t strobes_for(input phase_e p);
        strobes_t s;
        s = STROBES_OFF;
        case (p)
            PH_RD_ACC:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
            PH_WR_SETUP: begin s.ce_n = 1'b0; end
            PH_WR_PULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dout_en = 1'b1; end
            PH_WR_HOLD:  begin s.ce_n = 1'b0; s.dout_en = 1'b1; end
            default:     s = STROBES_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 1,
    parameter int TURN_CYC = 1,
    parameter int SU_CYC   = 1,
    parameter int PW_CYC   = 1,
    parameter int HOLD_CYC = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     req_we,
    output logic     accept,
    output logic     capture,
    output logic     done,
    output strobes_t strb
);

    localparam int MAX_A = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
    localparam int MAX_B = max3(SU_CYC, PW_CYC, HOLD_CYC);
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] C_RD   = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] C_TURN = CNT_W'(TURN_CYC);
    localparam logic [CNT_W-1:0] C_SU   = CNT_W'(SU_CYC);
    localparam logic [CNT_W-1:0] C_PW   = CNT_W'(PW_CYC);
    localparam logic [CNT_W-1:0] C_HOLD = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic             last;

    assign last = (cnt_q == C_ONE);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        done_d  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    accept  = 1'b1;
                    phase_d = req_we ? PH_WR_SETUP : PH_RD_ACC;
                    cnt_d   = req_we ? C_SU : C_RD;
                end
            end
            PH_RD_ACC: begin
                if (last) begin
                    capture = 1'b1;
                    done_d  = 1'b1;
                    phase_d = PH_RD_TURN;
                    cnt_d   = C_TURN;
                end else begin
                    cnt_d = cnt_q - C_ONE;
                end
            end
            PH_RD_TURN: begin
                if (last) phase_d = PH_IDLE;
                else      cnt_d   = cnt_q - C_ONE;
            end
            PH_WR_SETUP: begin
                if (last) begin
                    phase_d = PH_WR_PULSE;
                    cnt_d   = C_PW;
                end else begin
                    cnt_d = cnt_q - C_ONE;
                end
            end
            PH_WR_PULSE: begin
                if (last) begin
                    phase_d = PH_WR_HOLD;
                    cnt_d   = C_HOLD;
                end else begin
                    cnt_d = cnt_q - C_ONE;
                end
            end
            PH_WR_HOLD: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - C_ONE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            strb    <= STROBES_OFF;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            strb    <= strobes_for(phase_d);
            done    <= done_d;
        end
    end

    // R8: a busy controller takes nothing
    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (rst)
        accept |-> (phase_q == PH_IDLE));

    // R5: capture happens only while the read strobes are active
    assert_capture_in_read_R5: assert property (@(posedge clk) disable iff (rst)
        capture |-> (!strb.ce_n && !strb.oe_n && strb.we_n));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_din,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dout,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr <= '0;
            ram_dout <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                ram_addr <= req_addr;
                ram_dout <= req_wdata;
            end
            if (capture) begin
                rd_data <= ram_din;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_ADDR_ACC_PS = 10000,
    parameter int T_OE_ACC_PS   = 4000,
    parameter int T_RD_CYC_PS   = 10000,
    parameter int T_WR_CYC_PS   = 10000,
    parameter int T_WE_PW_PS    = 7000,
    parameter int T_ADDR_END_PS = 7000,
    parameter int T_DATA_SU_PS  = 5000,
    parameter int T_ADDR_SU_PS  = 0,
    parameter int T_RELEASE_PS  = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dout,
    input  logic [DATA_W-1:0] ram_din,
    output logic              ram_dout_en
);

    // R10: every phase length is a ceiling division, minimum one cycle
    localparam int RD_CYC   = max3(cycles_for(T_ADDR_ACC_PS, CLK_PERIOD_PS),
                                   cycles_for(T_OE_ACC_PS,   CLK_PERIOD_PS),
                                   cycles_for(T_RD_CYC_PS,   CLK_PERIOD_PS));
    localparam int TURN_CYC = cycles_for(T_RELEASE_PS, CLK_PERIOD_PS);
    localparam int SU_CYC   = cycles_for(T_ADDR_SU_PS, CLK_PERIOD_PS);
    localparam int PW_CYC   = max3(cycles_for(T_WE_PW_PS,    CLK_PERIOD_PS),
                                   cycles_for(T_ADDR_END_PS, CLK_PERIOD_PS),
                                   cycles_for(T_DATA_SU_PS,  CLK_PERIOD_PS));
    localparam int WC_CYC   = cycles_for(T_WR_CYC_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC = (WC_CYC > SU_CYC + PW_CYC) ? (WC_CYC - SU_CYC - PW_CYC) : 1;

    logic     accept;
    logic     capture;
    strobes_t strb;

    sram_ctrl_seq #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .SU_CYC   (SU_CYC),
        .PW_CYC   (PW_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_we  (req_we),
        .accept  (accept),
        .capture (capture),
        .done    (done),
        .strb    (strb)
    );

    sram_ctrl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) dp_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ram_din   (ram_din),
        .ram_addr  (ram_addr),
        .ram_dout  (ram_dout),
        .rd_data   (rd_data)
    );

    assign ram_ce_n    = strb.ce_n;
    assign ram_oe_n    = strb.oe_n;
    assign ram_we_n    = strb.we_n;
    assign ram_dout_en = strb.dout_en;

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dout_en && !done));

    assert_we_needs_ce_R2: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_ce_n);

    assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (ram_oe_n && ram_dout_en));

    assert_read_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (ram_we_n && !ram_ce_n));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

    assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (ram_dout_en && $past(ram_dout_en)) |-> $stable(ram_dout));

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        !(ram_dout_en && !ram_oe_n));

endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

    localparam int AW = 20;
    localparam int DW = 4;
    localparam int PER_PS = 3000;

    function automatic int cdiv(input int t, input int p);
        int c;
        c = (t + p - 1) / p;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(mx(cdiv(10000, PER_PS), cdiv(4000, PER_PS)), cdiv(10000, PER_PS));
    localparam int E_TURN = cdiv(5000, PER_PS);
    localparam int E_SU   = cdiv(0, PER_PS);
    localparam int E_PW   = mx(mx(cdiv(7000, PER_PS), cdiv(7000, PER_PS)), cdiv(5000, PER_PS));
    localparam int E_WC   = cdiv(10000, PER_PS);
    localparam int E_HOLD = (E_WC > E_SU + E_PW) ? E_WC - E_SU - E_PW : 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          done;
    logic [AW-1:0] ram_addr;
    logic          ram_ce_n, ram_oe_n, ram_we_n, ram_dout_en;
    logic [DW-1:0] ram_dout;
    logic [DW-1:0] ram_din;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    bit finished = 0;

    sram_ctrl #(.CLK_PERIOD_PS(PER_PS)) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dout(ram_dout), .ram_din(ram_din), .ram_dout_en(ram_dout_en)
    );

    always #5 clk = ~clk;

    // behavioural asynchronous RAM
    logic [DW-1:0] ram_mem [int];
    always @(posedge ram_we_n) begin
        if (ram_ce_n === 1'b0 && ram_dout_en === 1'b1) ram_mem[int'(ram_addr)] = ram_dout;
    end
    always @(ram_ce_n or ram_oe_n or ram_we_n or ram_addr) begin
        if (ram_ce_n === 1'b0 && ram_oe_n === 1'b0 && ram_we_n === 1'b1)
            ram_din = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : '0;
        else
            ram_din = '0;
    end

    // reference model: 0 idle, 1 read window, 2 release, 3 setup, 4 pulse, 5 hold
    logic [DW-1:0] shadow [int];
    int            m_ph = 0;
    int            m_cnt = 0;
    bit            m_acc = 0;
    bit            m_done = 0;
    bit            m_isw = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_rd = '0;

    always @(posedge clk) begin
        m_acc = 0;
        m_done = 0;
        if (rst) begin
            m_ph = 0;
            m_cnt = 0;
        end else begin
            case (m_ph)
                0: if (req) begin
                    m_acc = 1; m_addr = req_addr; m_wd = req_wdata; m_isw = req_we;
                    m_ph = req_we ? 3 : 1; m_cnt = req_we ? E_SU : E_RD;
                end
                1: if (m_cnt == 1) begin
                    m_rd = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : '0;
                    m_done = 1; m_ph = 2; m_cnt = E_TURN;
                end else m_cnt--;
                2: if (m_cnt == 1) m_ph = 0; else m_cnt--;
                3: if (m_cnt == 1) begin m_ph = 4; m_cnt = E_PW; end else m_cnt--;
                4: if (m_cnt == 1) begin m_ph = 5; m_cnt = E_HOLD; end else m_cnt--;
                5: if (m_cnt == 1) begin
                    m_ph = 0; m_done = 1; shadow[int'(m_addr)] = m_wd;
                end else m_cnt--;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, ncyc);
        end
    endtask

    int we_run = 0;
    int oe_run = 0;

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        ncyc++;
        if (rst) begin
            if (ncyc > 1) begin
                chk(ram_ce_n && ram_oe_n && ram_we_n && !ram_dout_en && !done, "R1",
                    "reset strobes", {ram_ce_n, ram_oe_n, ram_we_n, ram_dout_en, done}, 5'b11100);
            end
        end else begin
            bit e_ce, e_oe, e_we, e_den;
            e_ce  = (m_ph == 0 || m_ph == 2);
            e_oe  = (m_ph != 1);
            e_we  = (m_ph != 4);
            e_den = (m_ph == 4 || m_ph == 5);
            chk(ram_ce_n == e_ce, (m_ph == 2) ? "R6" : "R4", "ce_n", ram_ce_n, e_ce);
            chk(ram_oe_n == e_oe, (m_ph >= 3) ? "R3" : "R4", "oe_n", ram_oe_n, e_oe);
            chk(ram_we_n == e_we, "R2", "we_n", ram_we_n, e_we);
            chk(ram_dout_en == e_den, "R3", "dout_en", ram_dout_en, e_den);
            chk(done == m_done, "R7", "done", done, m_done);
            chk(!(ram_dout_en && !ram_oe_n), "R9", "bus contention", ram_dout_en, 0);
            if (m_ph != 0 && m_ph != 2)
                chk(ram_addr == m_addr, "R8", "ram_addr", ram_addr, m_addr);
            if (e_den)
                chk(ram_dout == m_wd, "R8", "ram_dout", ram_dout, m_wd);
            if (m_done && !m_isw)
                chk(rd_data == m_rd, "R5", "rd_data", rd_data, m_rd);
            // R10: measured strobe widths against the cycle counts
            if (!ram_we_n) we_run++;
            else if (we_run != 0) begin
                chk(we_run == E_PW, "R10", "we_n low cycles", we_run, E_PW);
                we_run = 0;
            end
            if (!ram_oe_n) oe_run++;
            else if (oe_run != 0) begin
                chk(oe_run == E_RD, "R10", "oe_n low cycles", oe_run, E_RD);
                oe_run = 0;
            end
        end
    end

    // drive a request and leave it up until the model takes it
    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        do begin
            @(posedge clk); #1;
        end while (!m_acc);
    endtask

    task automatic idle_wait();
        req = 1'b0;
        while (m_ph != 0) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R2 R3 R8: writes at the address extremes
        issue(1, 20'h00000, 4'h5); idle_wait();
        issue(1, 20'hFFFFF, 4'hA); idle_wait();
        issue(1, 20'h12345, 4'h3); idle_wait();
        // R4 R5: read them back, plus an unwritten location (expect 0)
        issue(0, 20'h00000, 4'h0); idle_wait();
        issue(0, 20'hFFFFF, 4'h0); idle_wait();
        issue(0, 20'h12345, 4'h0); idle_wait();
        issue(0, 20'h00777, 4'h0); idle_wait();

        // R6 R7: back-to-back with the request held high, read then write
        issue(1, 20'h00010, 4'h9);
        issue(0, 20'h00010, 4'h0);
        issue(1, 20'h00011, 4'h6);
        issue(0, 20'h00011, 4'h0);
        issue(1, 20'h00012, 4'hE);
        idle_wait();

        // R8: request raised while busy is ignored
        issue(1, 20'h00020, 4'h7);
        req = 1'b1; req_we = 1'b1; req_addr = 20'h00666; req_wdata = 4'hF;
        repeat (3) begin @(posedge clk); #1; end
        idle_wait();
        issue(0, 20'h00666, 4'h0); idle_wait();
        issue(0, 20'h00020, 4'h0); idle_wait();
        issue(0, 20'h00020, 4'h0);
        req_addr = 20'h00555;
        idle_wait();

        // overwrite then read
        issue(1, 20'h12345, 4'hC); idle_wait();
        issue(0, 20'h12345, 4'h0); idle_wait();

        // pattern sweep
        for (int i = 0; i < 16; i++) begin
            issue(1, AW'(i * 20'h0F0F1), DW'(15 - i));
        end
        for (int i = 0; i < 16; i++) begin
            issue(0, AW'(i * 20'h0F0F1), 4'h0);
        end
        idle_wait();
        repeat (4) @(posedge clk);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule